// File: doc/BRIEF.md
# SPI FIFO Interrupt Status and Mask Unit

This unit produces the single interrupt line of an SPI controller from the state of its transmit and receive FIFOs. It takes the two FIFO fill levels, a receive push strobe and a shifter byte-request strobe. From these it derives four live level conditions and two sticky error conditions. Each level condition is compared against a programmable threshold where one applies. A small register port gives access to several things: a status word, a mask that is set and cleared through two separate write-one addresses, and the two thresholds.

Software uses the transmit threshold to decide when the transmit FIFO counts as "not full". With the threshold at 1, that flag means "transmit FIFO empty". A driver needs this to know that a partial word may be written safely. The receive flag fires once the receive FIFO holds at least the receive-threshold number of words. The two error bits latch until software writes a one to them.

Register reads are combinational from `reg_addr`. Writes take effect at the clock edge that samples `reg_we`. The interrupt output is registered, so it follows the masked status with one cycle of delay.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the mask is 0, both thresholds are 1, both sticky bits are 0 and `irq` is low.
- R2: Status bit 2 (transmit below threshold) is 1 exactly when `tx_level` is less than the transmit threshold. With a threshold of 1 this bit means that the transmit FIFO is empty.
- R3: Status bit 3 is 1 when `tx_level` equals DEPTH. Status bit 5 is 1 when `rx_level` equals DEPTH.
- R4: Status bit 4 is 1 when `rx_level` is greater than or equal to the receive threshold.
- R5: Status bit 0 (receive overflow) is set in the cycle after `rx_push` is seen while `rx_level` equals DEPTH. It then holds until it is cleared.
- R6: Status bit 6 (transmit underflow) is set in the cycle after `shift_req` is seen with `xfer_active` high and `tx_level` equal to 0. It is not set when either of those conditions is missing, and it holds until it is cleared.
- R7: A write to status offset 0x04 clears each sticky bit (0 and 6) whose data bit is 1. Data bits that are 0 leave the sticky bits unchanged. If a set event and a clear arrive in the same cycle, the set wins.
- R8: Writes to the status offset do not change the level bits 2 through 5.
- R9: A write to 0x08 ORs the data into the mask, and a write to 0x0C clears the mask bits whose data bit is 1. The mask reads back at 0x10. Only bits 6, 5, 4, 3, 2 and 0 are implemented. Offsets 0x08, 0x0C and any unmapped offset read as 0.
- R10: `irq` is 1 in the cycle after any status bit and its mask bit are both 1, and 0 otherwise.
- R11: The transmit threshold is read and written at 0x28, and the receive threshold at 0x2C.
- R12: Writing all ones to 0x04 and then to 0x0C leaves the mask at 0, both sticky bits at 0 and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| tx_level | input | CNT_W | Words held in the transmit FIFO |
| rx_level | input | CNT_W | Words held in the receive FIFO |
| rx_push | input | 1 | Serial engine pushes a received word |
| shift_req | input | 1 | Shifter requests the next transmit byte |
| xfer_active | input | 1 | A transfer is in progress |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the threshold edges. At threshold 1 with one word in the FIFO, a design that used less-or-equal would report the transmit FIFO as empty when it is not. At a receive level one below the threshold, a design that used a strict compare would raise the receive flag one word late or one word early. The bench also drives a set event and a write-one clear of the same sticky bit in one cycle; a design that gave the clear priority would lose the overflow. It writes all ones to status while the level bits are high, which exposes a design that lets writes reach the live flags. It also checks that an underflow needs an active transfer, and that `irq` rises exactly one cycle after the pending condition appears.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int SRC_W = 7;

  localparam logic [7:0] A_STATUS   = 8'h04;
  localparam logic [7:0] A_MASK_SET = 8'h08;
  localparam logic [7:0] A_MASK_CLR = 8'h0C;
  localparam logic [7:0] A_MASK_RD  = 8'h10;
  localparam logic [7:0] A_TX_THR   = 8'h28;
  localparam logic [7:0] A_RX_THR   = 8'h2C;

  localparam int B_OVF  = 0;
  localparam int B_TXLO = 2;
  localparam int B_TXF  = 3;
  localparam int B_RXRD = 4;
  localparam int B_RXF  = 5;
  localparam int B_UNF  = 6;

  localparam logic [SRC_W-1:0] SRC_IMPL    = 7'b1111101;
  localparam logic [SRC_W-1:0] STICKY_BITS = 7'b1000001;

  typedef struct packed {
    logic rx_full;
    logic rx_ready;
    logic tx_full;
    logic tx_below;
  } lvl_flags_t;

  function automatic logic [SRC_W-1:0] pack_status(lvl_flags_t f,
                                                   logic [SRC_W-1:0] sticky);
    logic [SRC_W-1:0] s;
    s          = sticky & STICKY_BITS;
    s[B_TXLO]  = f.tx_below;
    s[B_TXF]   = f.tx_full;
    s[B_RXRD]  = f.rx_ready;
    s[B_RXF]   = f.rx_full;
    return s;
  endfunction

endpackage

// File: rtl/spi_irq_levels.sv
module spi_irq_levels
  import spi_irq_pkg::*;
#(
  parameter int DEPTH  = 63,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int THR_W  = 8
) (
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  output lvl_flags_t       flags
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  function automatic logic lvl_below(logic [CNT_W-1:0] lvl, logic [THR_W-1:0] thr);
    return CMP_W'(lvl) < CMP_W'(thr);
  endfunction

  function automatic logic lvl_at_full(logic [CNT_W-1:0] lvl);
    return 32'(lvl) == DEPTH;
  endfunction

  always_comb begin
    flags.tx_below = lvl_below(tx_level, tx_thr);
    flags.tx_full  = lvl_at_full(tx_level);
    flags.rx_ready = !lvl_below(rx_level, rx_thr);
    flags.rx_full  = lvl_at_full(rx_level);
  end

  // R3 / R2: a full transmit FIFO never reads as below a reachable threshold
  always_comb begin
    if (32'(tx_thr) <= DEPTH) begin
      a_r3_full_not_below: assert (!(flags.tx_full && flags.tx_below));
    end
  end

endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r5_sets_next: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r5_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int THR_W  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [SRC_W-1:0]  mask_o,
  output logic [THR_W-1:0]  tx_thr_o,
  output logic [THR_W-1:0]  rx_thr_o,
  output logic [SRC_W-1:0]  sticky_clr_o
);

  logic wr_set, wr_clr, wr_stat, wr_txt, wr_rxt;
  logic [SRC_W-1:0] wbits;

  assign wr_set  = reg_we && (reg_addr == A_MASK_SET);
  assign wr_clr  = reg_we && (reg_addr == A_MASK_CLR);
  assign wr_stat = reg_we && (reg_addr == A_STATUS);
  assign wr_txt  = reg_we && (reg_addr == A_TX_THR);
  assign wr_rxt  = reg_we && (reg_addr == A_RX_THR);
  assign wbits   = reg_wdata[SRC_W-1:0];

  assign sticky_clr_o = wr_stat ? (wbits & STICKY_BITS) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
    end else if (wr_set) begin
      mask_o <= (mask_o | wbits) & SRC_IMPL;
    end else if (wr_clr) begin
      mask_o <= mask_o & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_o <= THR_W'(1);
      rx_thr_o <= THR_W'(1);
    end else begin
      if (wr_txt) tx_thr_o <= reg_wdata[THR_W-1:0];
      if (wr_rxt) rx_thr_o <= reg_wdata[THR_W-1:0];
    end
  end

  a_r9_mask_or: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_o & $past(wbits & SRC_IMPL)) == $past(wbits & SRC_IMPL)));
  a_r9_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_o & $past(wbits)) == '0));

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH  = 63,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              rx_push,
  input  logic              shift_req,
  input  logic              xfer_active,
  output logic              irq
);

  localparam int THR_W = DATA_W;

  logic [SRC_W-1:0] mask_q, sticky_clr, sticky_evt, sticky_q, status;
  logic [THR_W-1:0] tx_thr, rx_thr;
  lvl_flags_t       flags;
  logic             ovf_evt, unf_evt, pend_any;

  spi_irq_regs #(.DATA_W(DATA_W), .THR_W(THR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .mask_o      (mask_q),
    .tx_thr_o    (tx_thr),
    .rx_thr_o    (rx_thr),
    .sticky_clr_o(sticky_clr)
  );

  spi_irq_levels #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_levels (
    .tx_level(tx_level),
    .rx_level(rx_level),
    .tx_thr  (tx_thr),
    .rx_thr  (rx_thr),
    .flags   (flags)
  );

  // error events, named for the checkers
  assign ovf_evt = rx_push && flags.rx_full;
  assign unf_evt = shift_req && xfer_active && (tx_level == '0);

  always_comb begin
    sticky_evt         = '0;
    sticky_evt[B_OVF]  = ovf_evt;
    sticky_evt[B_UNF]  = unf_evt;
  end

  for (genvar g = 0; g < SRC_W; g++) begin : g_src
    if (STICKY_BITS[g]) begin : g_sticky
      spi_irq_sticky u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(sticky_evt[g]),
        .clr_i(sticky_clr[g]),
        .q_o  (sticky_q[g])
      );
    end else begin : g_live
      assign sticky_q[g] = 1'b0;
    end
  end

  assign status   = pack_status(flags, sticky_q);
  assign pend_any = |(status & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pend_any;
  end

  always_comb begin
    unique case (reg_addr)
      A_STATUS:  reg_rdata = DATA_W'(status);
      A_MASK_RD: reg_rdata = DATA_W'(mask_q);
      A_TX_THR:  reg_rdata = tx_thr;
      A_RX_THR:  reg_rdata = rx_thr;
      default:   reg_rdata = '0;
    endcase
  end

  a_r12_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);
  a_r6_underflow_latched: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> sticky_q[B_UNF]);

endmodule

// File: tb/spi_fifo_irq_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_test;

  localparam int DEPTH = 63;
  localparam int CNT_W = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [CNT_W-1:0] tx_level = 0, rx_level = 0;
  logic rx_push = 0, shift_req = 0, xfer_active = 0;
  logic irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit started = 0;

  always #2.5 clk = ~clk;

  spi_fifo_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
    .rx_level(rx_level), .rx_push(rx_push), .shift_req(shift_req),
    .xfer_active(xfer_active), .irq(irq)
  );

  // behavioural reference state
  int m_mask, m_txt, m_rxt, m_irq;
  bit m_ovf, m_unf;

  function automatic int exp_status();
    int s = 0;
    if (int'(tx_level) < m_txt)  s |= 'h04;
    if (int'(tx_level) == DEPTH) s |= 'h08;
    if (int'(rx_level) >= m_rxt) s |= 'h10;
    if (int'(rx_level) == DEPTH) s |= 'h20;
    if (m_ovf) s |= 'h01;
    if (m_unf) s |= 'h40;
    return s;
  endfunction

  function automatic int exp_read(int a);
    case (a)
      'h04: return exp_status();
      'h10: return m_mask;
      'h28: return m_txt;
      'h2C: return m_rxt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_txt = 1; m_rxt = 1; m_irq = 0; m_ovf = 0; m_unf = 0;
    end else begin
      bit set_o, set_u, clr_o, clr_u;
      m_irq = ((exp_status() & m_mask) != 0) ? 1 : 0;
      set_o = rx_push && (int'(rx_level) == DEPTH);
      set_u = shift_req && xfer_active && (tx_level == 0);
      clr_o = reg_we && reg_addr == 8'h04 && reg_wdata[0];
      clr_u = reg_we && reg_addr == 8'h04 && reg_wdata[6];
      m_ovf = set_o ? 1'b1 : (clr_o ? 1'b0 : m_ovf);
      m_unf = set_u ? 1'b1 : (clr_u ? 1'b0 : m_unf);
      if (reg_we) begin
        case (reg_addr)
          8'h08: m_mask = (m_mask | int'(reg_wdata)) & 'h7D;
          8'h0C: m_mask = m_mask & ~int'(reg_wdata) & 'h7F;
          8'h28: m_txt = int'(reg_wdata);
          8'h2C: m_rxt = int'(reg_wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && started) begin
      check(cur_req, "irq", int'(irq), m_irq);
      check(cur_req, "rdata", int'(reg_rdata), exp_read(int'(reg_addr)));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(string req, input logic [7:0] a, input int exp);
    reg_addr = a;
    @(negedge clk); #1;
    check(req, "read", int'(reg_rdata), exp);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; started = 1;
    tick();

    cur_req = "R1";
    rd("R1", 8'h10, 0);
    rd("R1", 8'h28, 1);
    rd("R1", 8'h2C, 1);
    rd("R1", 8'h04, 'h04);
    check("R1", "irq", int'(irq), 0);

    cur_req = "R2";
    tx_level = 1; rd("R2", 8'h04, 'h00);
    tx_level = 0; rd("R2", 8'h04, 'h04);
    cur_req = "R11";
    wr(8'h28, 8'd4); rd("R11", 8'h28, 4);
    cur_req = "R2";
    tx_level = 3; rd("R2", 8'h04, 'h04);
    tx_level = 4; rd("R2", 8'h04, 'h00);

    cur_req = "R3";
    tx_level = 63; rd("R3", 8'h04, 'h08);
    rx_level = 63; rd("R3", 8'h04, 'h38);

    cur_req = "R4";
    wr(8'h2C, 8'd5); rd("R11", 8'h2C, 5);
    rx_level = 4; rd("R4", 8'h04, 'h08);
    rx_level = 5; rd("R4", 8'h04, 'h18);

    cur_req = "R8";
    wr(8'h04, 8'hFF); rd("R8", 8'h04, 'h18);

    cur_req = "R5";
    rx_level = 63; rx_push = 1; tick(); rx_push = 0;
    rd("R5", 8'h04, 'h39);
    rx_level = 0; repeat (3) tick();
    rd("R5", 8'h04, 'h09);

    cur_req = "R7";
    wr(8'h04, 8'h40); rd("R7", 8'h04, 'h09);
    wr(8'h04, 8'h01); rd("R7", 8'h04, 'h08);
    rx_level = 63; rx_push = 1; reg_we = 1; reg_addr = 8'h04; reg_wdata = 8'h01;
    tick(); rx_push = 0; reg_we = 0;
    rd("R7", 8'h04, 'h39);
    wr(8'h04, 8'h01); rx_level = 0; rd("R7", 8'h04, 'h08);

    cur_req = "R6";
    wr(8'h28, 8'd1);
    tx_level = 0; shift_req = 1; xfer_active = 0; tick();
    rd("R6", 8'h04, 'h04);
    tx_level = 2; xfer_active = 1; tick();
    rd("R6", 8'h04, 'h00);
    tx_level = 0; tick(); shift_req = 0; xfer_active = 0;
    rd("R6", 8'h04, 'h44);
    wr(8'h04, 8'h40); rd("R6", 8'h04, 'h04);

    cur_req = "R9";
    wr(8'h08, 8'hFF); rd("R9", 8'h10, 'h7D);
    wr(8'h0C, 8'h10); rd("R9", 8'h10, 'h6D);
    rd("R9", 8'h08, 0);
    rd("R9", 8'h0C, 0);
    rd("R9", 8'h3C, 0);

    cur_req = "R10";
    wr(8'h0C, 8'hFF); wr(8'h2C, 8'd1);
    wr(8'h08, 8'h10);
    rx_level = 0; tick(); tick();
    rx_level = 1;
    @(negedge clk); #1 check("R10", "irq same cycle", int'(irq), 0);
    @(negedge clk); #1 check("R10", "irq next cycle", int'(irq), 1);
    tick();
    rx_level = 0; tick(); tick();
    @(negedge clk); #1 check("R10", "irq drops", int'(irq), 0);
    tick();

    cur_req = "R12";
    wr(8'h08, 8'hFF);
    rx_level = 63; rx_push = 1; shift_req = 1; xfer_active = 1; tick();
    rx_push = 0; shift_req = 0; xfer_active = 0; tick();
    wr(8'h04, 8'hFF);
    wr(8'h0C, 8'hFF);
    tick();
    rd("R12", 8'h10, 0);
    check("R12", "irq", int'(irq), 0);
    rd("R12", 8'h04, 'h34);

    repeat (4) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule